// File: doc/BRIEF.md
# Variable Refresh Vertical Timing Generator

This block sequences the vertical timing of one display pipe whose frame length may stretch between a programmed minimum and maximum number of lines. An external strobe marks each line boundary. The block counts lines through active video and into vertical blank. In blank it decides when to leave: as soon as software requests it, but never before a minimum point and never later than a maximum boundary. It then runs a blank-exit window of fixed length and wraps to line zero with a frame-start pulse.

Software programs the block through a small write port. There is a control word, four line-count registers, an active-line count and a push register. The timing registers are double-buffered: a written value waits in a pending copy and moves to the working copy only when a blank exit begins. When variable refresh is off, the block runs a fixed frame of programmable length.

Top module: `vrr_vtiming_gen`

## Requirements
- R1: After reset, `line_num` is 0, `in_blank` is low, all three strobes are low, and the block runs fixed timing with a total of `RST_TOTAL` lines and `RST_ACTIVE` active lines.
- R2: The register map is as follows. Address 0 is the control word: bit 0 turns variable refresh on, bit 1 selects the flip line as the minimum, bit 2 selects the programmed pipeline length, bits 5:4 give the start delay and bits 15:8 the pipeline length. The line-count registers sit at address 1 (minimum total), address 2 (maximum total), address 3 (flip line) and address 5 (fixed total). Each holds its line count minus one. Address 4 holds the active-line count as is. Address 6 is the push register: bit 0 is the enable and bit 1 is the send request.
- R3: With variable refresh off, every frame is exactly the fixed total long. The blank exit starts at fixed total minus (start delay + 1). Push writes do not change the frame length.
- R4: `vblank_start` pulses when the line counter reaches the active-line count, and `in_blank` stays high from then until the frame wraps.
- R5: With variable refresh on, the exit window lasts E = P + D + 1 lines. D is the start delay. P is the programmed pipeline length when bit 2 is set, and otherwise the parameter `DEF_PIPE_FULL`.
- R6: With variable refresh on and no push, the exit starts on line maximum total − E, so the frame is maximum total lines long.
- R7: With variable refresh on, a push written during line p, with p + 1 at or after the earliest exit line, starts the exit on line p + 1. The exit is never later than maximum total − E and never before the active-line count.
- R8: A push written before the earliest exit line is held. The exit then starts on that line, which is the minimum frame length minus E. The minimum frame length is the flip line when bit 1 is set, and otherwise the minimum total.
- R9: A push is honoured only when both its enable and its send bits are set. With only one of them set, the frame runs to the maximum total.
- R10: The send bit clears itself when an exit starts while a push is honoured, so the next frame without a new push runs to the maximum total.
- R11: Values written to registers 0 to 5 take effect only at the start of the next blank exit. A frame already under way keeps its old values for its frame length.
- R12: Writing zero to the control word returns the block to fixed timing from the frame after the next exit start.
- R13: Each strobe is high for exactly one clock, in the clock after the line strobe that caused it. `frame_start` coincides with `line_num` returning to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_adv | input | 1 | One-clock strobe marking a line boundary |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 3 | Register address |
| wr_data | input | LINE_W | Register write data |
| line_num | output | LINE_W | Current line within the frame |
| in_blank | output | 1 | High from the first blank line to the end of the frame |
| vblank_start | output | 1 | Pulse on entry to vertical blank |
| exit_start | output | 1 | Pulse on the first line of the blank exit window |
| frame_start | output | 1 | Pulse when the next frame begins at line 0 |

## Verification
The bench sweeps every start delay with and without the pipeline-length override. For each setting it writes a push on every line of the frame and predicts the exit line and the frame length arithmetically. This catches an exit window off by one line, a push acted on one line late, or a push honoured before the minimum. The largest exit window pushes the earliest exit line below the active-line count, which catches a design that leaves blank before it has entered it. Separate frames check three further faults: a push lost or repeated because the send bit failed to clear, a register write that leaked into the running frame, and pipeline length or push still counted in fixed timing.

// File: rtl/vrr_pkg.sv
package vrr_pkg;

    // Register addresses; order is part of the programming interface
    typedef enum logic [2:0] {
        REG_CTRL   = 3'd0,
        REG_MIN    = 3'd1,
        REG_MAX    = 3'd2,
        REG_FLIP   = 3'd3,
        REG_ACTIVE = 3'd4,
        REG_FIXED  = 3'd5,
        REG_PUSH   = 3'd6,
        REG_SPARE  = 3'd7
    } reg_addr_e;

    // Working form of the control word
    typedef struct packed {
        logic [7:0] pipe_full;
        logic [1:0] fs_delay;
        logic       pf_ovr;
        logic       flip_en;
        logic       vrr_en;
    } ctrl_t;

    typedef enum logic [1:0] {
        PH_ACTIVE = 2'd0,
        PH_BLANK  = 2'd1,
        PH_EXIT   = 2'd2
    } phase_e;

    localparam int SPAN_W = 10;

    // Length in lines of the blank exit window
    function automatic logic [SPAN_W-1:0] exit_span(input ctrl_t c, input logic [7:0] def_pf);
        logic [7:0] pf;
        if (!c.vrr_en)
            pf = 8'd0;
        else if (c.pf_ovr)
            pf = c.pipe_full;
        else
            pf = def_pf;
        return {2'b00, pf} + {8'd0, c.fs_delay} + 10'd1;
    endfunction

endpackage

// File: rtl/vrr_cfg_regs.sv
module vrr_cfg_regs
    import vrr_pkg::*;
#(
    parameter int LINE_W     = 16,   // at least 16 so the control word fits
    parameter int RST_ACTIVE = 8,
    parameter int RST_TOTAL  = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [LINE_W-1:0] wr_data,
    input  logic              latch,
    input  logic              consume,
    output ctrl_t             act_ctrl,
    output logic [LINE_W-1:0] act_min_m1,
    output logic [LINE_W-1:0] act_max_m1,
    output logic [LINE_W-1:0] act_flip_m1,
    output logic [LINE_W-1:0] act_active,
    output logic [LINE_W-1:0] act_fixed_m1,
    output logic              push_req
);

    localparam int NLREG = 5;   // line-count registers at addresses 1..5

    ctrl_t pend_ctrl, ctrl_q;
    logic  push_en_q, push_send_q;

    // Line-count registers: pending copy plus working copy each
    for (genvar g = 0; g < NLREG; g++) begin : g_line
        localparam logic [2:0] ADDR = 3'(g + 1);
        localparam logic [LINE_W-1:0] RV =
            (g == 3) ? LINE_W'(RST_ACTIVE) :
            (g == 4) ? LINE_W'(RST_TOTAL - 1) : '0;
        logic [LINE_W-1:0] pend_q;
        logic [LINE_W-1:0] act_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                pend_q <= RV;
                act_q  <= RV;
            end else begin
                if (wr_en && wr_addr == ADDR)
                    pend_q <= wr_data;
                if (latch)
                    act_q <= pend_q;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_ctrl <= '0;
            ctrl_q    <= '0;
        end else begin
            if (wr_en && wr_addr == 3'(REG_CTRL)) begin
                pend_ctrl.vrr_en    <= wr_data[0];
                pend_ctrl.flip_en   <= wr_data[1];
                pend_ctrl.pf_ovr    <= wr_data[2];
                pend_ctrl.fs_delay  <= wr_data[5:4];
                pend_ctrl.pipe_full <= wr_data[15:8];
            end
            if (latch)
                ctrl_q <= pend_ctrl;
        end
    end

    // Push register acts at once; send clears when consumed
    always_ff @(posedge clk) begin
        if (rst) begin
            push_en_q   <= 1'b0;
            push_send_q <= 1'b0;
        end else if (wr_en && wr_addr == 3'(REG_PUSH)) begin
            push_en_q   <= wr_data[0];
            push_send_q <= wr_data[1];
        end else if (consume) begin
            push_send_q <= 1'b0;
        end
    end

    assign act_ctrl     = ctrl_q;
    assign act_min_m1   = g_line[0].act_q;
    assign act_max_m1   = g_line[1].act_q;
    assign act_flip_m1  = g_line[2].act_q;
    assign act_active   = g_line[3].act_q;
    assign act_fixed_m1 = g_line[4].act_q;
    assign push_req     = push_en_q & push_send_q;

    // R11: working copies move only on a latch request
    a_r11_hold_between_latches: assert property (@(posedge clk) disable iff (rst)
        !latch |=> ($stable(ctrl_q) && $stable(g_line[1].act_q) && $stable(g_line[2].act_q)
                    && $stable(g_line[3].act_q)));

    // R10: a consumed push leaves the send bit clear
    a_r10_send_clears: assert property (@(posedge clk) disable iff (rst)
        (consume && !(wr_en && wr_addr == 3'(REG_PUSH))) |=> !push_send_q);

endmodule

// File: rtl/vrr_bound_calc.sv
module vrr_bound_calc
    import vrr_pkg::*;
#(
    parameter int LINE_W        = 16,
    parameter int DEF_PIPE_FULL = 2
) (
    input  ctrl_t             ctrl,
    input  logic [LINE_W-1:0] min_m1,
    input  logic [LINE_W-1:0] max_m1,
    input  logic [LINE_W-1:0] flip_m1,
    input  logic [LINE_W-1:0] fixed_m1,
    output logic              vrr_on,
    output logic [LINE_W-1:0] exit_len,
    output logic [LINE_W-1:0] earliest,
    output logic [LINE_W-1:0] latest,
    output logic [LINE_W-1:0] fixed_exit
);

    localparam int XW = LINE_W + 1;

    logic [SPAN_W-1:0] span;
    logic [XW-1:0]     min_tot, max_tot, fix_tot;

    // Subtract with a floor at zero
    function automatic logic [LINE_W-1:0] sub_floor(input logic [XW-1:0] a, input logic [LINE_W-1:0] b);
        if (a > {1'b0, b})
            return LINE_W'(a - {1'b0, b});
        else
            return '0;
    endfunction

    assign span     = exit_span(ctrl, 8'(DEF_PIPE_FULL));
    assign exit_len = LINE_W'(span);
    assign vrr_on   = ctrl.vrr_en;

    // Stored values are count minus one
    assign min_tot = {1'b0, (ctrl.flip_en ? flip_m1 : min_m1)} + XW'(1);
    assign max_tot = {1'b0, max_m1} + XW'(1);
    assign fix_tot = {1'b0, fixed_m1} + XW'(1);

    assign earliest   = sub_floor(min_tot, exit_len);
    assign latest     = sub_floor(max_tot, exit_len);
    assign fixed_exit = sub_floor(fix_tot, exit_len);

endmodule

// File: rtl/vrr_line_seq.sv
module vrr_line_seq
    import vrr_pkg::*;
#(
    parameter int LINE_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_adv,
    input  logic              vrr_on,
    input  logic              push_req,
    input  logic [LINE_W-1:0] exit_len,
    input  logic [LINE_W-1:0] earliest,
    input  logic [LINE_W-1:0] latest,
    input  logic [LINE_W-1:0] fixed_exit,
    input  logic [LINE_W-1:0] active_lines,
    output logic              latch,
    output logic              consume,
    output logic [LINE_W-1:0] line_num,
    output logic              in_blank,
    output logic              vblank_start,
    output logic              exit_start,
    output logic              frame_start
);

    phase_e            phase_q;
    logic [LINE_W-1:0] line_q, nxt, exit_left_q;
    logic              vbs_q, es_q, fs_q;
    logic              going_blank, start_ok, start, wrap;

    assign nxt         = line_q + LINE_W'(1);
    assign going_blank = (nxt >= active_lines);

    always_comb begin
        if (vrr_on)
            start_ok = (nxt >= latest) || ((nxt >= earliest) && push_req);
        else
            start_ok = (nxt >= fixed_exit);
    end

    assign start   = line_adv && (phase_q != PH_EXIT) && going_blank && start_ok;
    assign wrap    = line_adv && (phase_q == PH_EXIT) && (exit_left_q == '0);
    assign latch   = start;
    assign consume = start && vrr_on && push_req;

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q      <= '0;
            phase_q     <= PH_ACTIVE;
            exit_left_q <= '0;
            vbs_q       <= 1'b0;
            es_q        <= 1'b0;
            fs_q        <= 1'b0;
        end else begin
            vbs_q <= line_adv && (phase_q == PH_ACTIVE) && going_blank;
            es_q  <= start;
            fs_q  <= wrap;
            if (line_adv) begin
                if (wrap) begin
                    line_q  <= '0;
                    phase_q <= PH_ACTIVE;
                end else begin
                    line_q <= nxt;
                    if (start) begin
                        phase_q     <= PH_EXIT;
                        exit_left_q <= exit_len - LINE_W'(1);
                    end else if (phase_q == PH_EXIT) begin
                        exit_left_q <= exit_left_q - LINE_W'(1);
                    end else if (going_blank) begin
                        phase_q <= PH_BLANK;
                    end
                end
            end
        end
    end

    assign line_num     = line_q;
    assign in_blank     = (phase_q != PH_ACTIVE);
    assign vblank_start = vbs_q;
    assign exit_start   = es_q;
    assign frame_start  = fs_q;

    // R13: a new frame begins at line zero
    a_r13_frame_at_zero: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> (line_num == '0));

    // R13: strobes follow a line boundary
    a_r13_strobe_follows_adv: assert property (@(posedge clk) disable iff (rst)
        (vblank_start || exit_start || frame_start) |-> $past(line_adv));

    // R13: exit start and frame start never share a clock
    a_r13_exit_frame_apart: assert property (@(posedge clk) disable iff (rst)
        $onehot0({exit_start, frame_start}));

    // R4: blank entry is reflected in the blank flag
    a_r4_blank_on_entry: assert property (@(posedge clk) disable iff (rst)
        vblank_start |-> in_blank);

endmodule

// File: rtl/vrr_vtiming_gen.sv
module vrr_vtiming_gen
    import vrr_pkg::*;
#(
    parameter int LINE_W        = 16,
    parameter int RST_ACTIVE    = 8,
    parameter int RST_TOTAL     = 12,
    parameter int DEF_PIPE_FULL = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_adv,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [LINE_W-1:0] wr_data,
    output logic [LINE_W-1:0] line_num,
    output logic              in_blank,
    output logic              vblank_start,
    output logic              exit_start,
    output logic              frame_start
);

    ctrl_t             act_ctrl;
    logic [LINE_W-1:0] min_m1, max_m1, flip_m1, active_l, fixed_m1;
    logic [LINE_W-1:0] exit_len, earliest, latest, fixed_exit;
    logic              push_req, vrr_on, latch, consume;

    vrr_cfg_regs #(
        .LINE_W    (LINE_W),
        .RST_ACTIVE(RST_ACTIVE),
        .RST_TOTAL (RST_TOTAL)
    ) u_regs (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .latch       (latch),
        .consume     (consume),
        .act_ctrl    (act_ctrl),
        .act_min_m1  (min_m1),
        .act_max_m1  (max_m1),
        .act_flip_m1 (flip_m1),
        .act_active  (active_l),
        .act_fixed_m1(fixed_m1),
        .push_req    (push_req)
    );

    vrr_bound_calc #(
        .LINE_W       (LINE_W),
        .DEF_PIPE_FULL(DEF_PIPE_FULL)
    ) u_calc (
        .ctrl      (act_ctrl),
        .min_m1    (min_m1),
        .max_m1    (max_m1),
        .flip_m1   (flip_m1),
        .fixed_m1  (fixed_m1),
        .vrr_on    (vrr_on),
        .exit_len  (exit_len),
        .earliest  (earliest),
        .latest    (latest),
        .fixed_exit(fixed_exit)
    );

    vrr_line_seq #(
        .LINE_W(LINE_W)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .line_adv    (line_adv),
        .vrr_on      (vrr_on),
        .push_req    (push_req),
        .exit_len    (exit_len),
        .earliest    (earliest),
        .latest      (latest),
        .fixed_exit  (fixed_exit),
        .active_lines(active_l),
        .latch       (latch),
        .consume     (consume),
        .line_num    (line_num),
        .in_blank    (in_blank),
        .vblank_start(vblank_start),
        .exit_start  (exit_start),
        .frame_start (frame_start)
    );

endmodule

// File: tb/tb_vrr_vtiming_gen.sv
`timescale 1ns/1ps
module tb_vrr_vtiming_gen;

    localparam int LW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          line_adv = 1'b0;
    logic          wr_en = 1'b0;
    logic [2:0]    wr_addr = '0;
    logic [LW-1:0] wr_data = '0;
    logic [LW-1:0] line_num;
    logic          in_blank, vblank_start, exit_start, frame_start;

    int  nchk = 0;
    int  nfail = 0;
    bit  finished = 0;
    int  got_t, got_x, got_v;

    always #2.5 clk = ~clk;

    vrr_vtiming_gen dut (
        .clk(clk), .rst(rst), .line_adv(line_adv),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .line_num(line_num), .in_blank(in_blank),
        .vblank_start(vblank_start), .exit_start(exit_start), .frame_start(frame_start)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input int addr, input int data);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'(addr); wr_data = LW'(data);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic adv();
        @(negedge clk);
        line_adv = 1'b1;
        @(negedge clk);
        line_adv = 1'b0;
    endtask

    // Run one frame from line 0; optionally write a register on line at_line
    task automatic run_frame(input int at_line, input int addr, input int data,
                             input string req, input int exp_t, input int exp_x);
        int  cnt = 0;
        bit  done = 0;
        got_x = -1; got_v = -1;
        while (!done && cnt < 600) begin
            if (at_line >= 0 && int'(line_num) == at_line) wr(addr, data);
            adv();
            cnt++;
            if (exit_start)   got_x = int'(line_num);
            if (vblank_start) got_v = int'(line_num);
            if (frame_start)  done = 1;
        end
        got_t = cnt;
        chk(got_t == exp_t, {req, " frame length"}, got_t, exp_t);
        if (exp_x >= 0) chk(got_x == exp_x, {req, " exit line"}, got_x, exp_x);
        @(negedge clk);
        // R13: strobes are one clock wide
        chk(!frame_start && !exit_start && !vblank_start, "R13 pulse width",
            int'(frame_start), 0);
    endtask

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            nchk++; nfail++;
            $display("FAIL watchdog: got %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(line_num == 0, "R1 line", int'(line_num), 0);
        chk(!in_blank && !vblank_start && !exit_start && !frame_start, "R1 outputs",
            int'(in_blank), 0);

        // R1 R3 R4: fixed timing from reset (total 12, active 8, exit at 11)
        run_frame(-1, 0, 0, "R1 R3", 12, 11);
        chk(got_v == 8, "R4 vblank line", got_v, 8);
        // R3: push ignored in fixed timing
        run_frame(2, 6, 3, "R3 push ignored", 12, 11);
        wr(6, 0);

        // R11: VRR setup written; current frame stays fixed
        wr(1, 14); wr(2, 29); wr(3, 15);
        wr(0, 1 | 2 | 4 | (1 << 4) | (2 << 8));   // E = 2+1+1 = 4
        run_frame(-1, 0, 0, "R11 pending", 12, 11);

        // R2 R6: no push -> max total 30, exit at 26
        run_frame(-1, 0, 0, "R2 R6", 30, 26);
        // R8: early push -> flip line 16, exit 12
        run_frame(0, 6, 3, "R8 early push", 16, 12);
        // R10: send cleared, back to max
        run_frame(-1, 0, 0, "R10 self clear", 30, 26);
        // R7: push on line 20 -> exit 21
        run_frame(20, 6, 3, "R7 mid push", 25, 21);
        // R9: enable only, send only
        run_frame(9, 6, 1, "R9 enable only", 30, 26);
        run_frame(9, 6, 2, "R9 send only", 30, 26);
        wr(6, 0);

        // R5 R7 R8: sweep delay, override and push line
        for (int fsd = 0; fsd < 4; fsd++) begin
            for (int ovr = 0; ovr < 2; ovr++) begin
                int e, ear, lat;
                wr(0, 1 | 2 | (ovr << 2) | (fsd << 4) | (5 << 8));
                run_frame(-1, 0, 0, "R11 latch frame", 30, -1);
                e   = (ovr != 0 ? 5 : 2) + fsd + 1;
                ear = 16 - e;
                lat = 30 - e;
                for (int p = 0; p < lat; p++) begin
                    int x;
                    x = imax(imax(ear, 8), p + 1);
                    run_frame(p, 6, 3, "R5 R7 sweep", x + e, x);
                end
            end
        end

        // R8: flip select off -> minimum total 15
        wr(0, 1 | 4 | (1 << 4) | (2 << 8));
        run_frame(-1, 0, 0, "R11 latch frame", 30, -1);
        run_frame(0, 6, 3, "R8 min total", 15, 11);

        // R11: max total rewritten mid frame
        run_frame(2, 2, 19, "R11 old max", 30, 26);
        run_frame(-1, 0, 0, "R11 new max", 20, 16);

        // R12: disable returns to fixed timing
        wr(6, 0);
        run_frame(0, 0, 0, "R12 last vrr frame", 20, 16);
        run_frame(3, 6, 3, "R12 fixed", 12, 11);
        wr(6, 0);

        // R3: fixed exit follows start delay (D=2 -> exit at 9)
        run_frame(0, 0, (2 << 4), "R3 latch frame", 12, 11);
        run_frame(-1, 0, 0, "R3 delay", 12, 9);

        finished = 1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

endmodule